// File: doc/BRIEF.md
# Dual-Endian Byte-Addressed Data Store

This block is a small data memory in which every address names a single byte. A request can move a byte, a 16-bit half-word or a 32-bit word. For multi-byte accesses the requester also picks, on every request, which end of the value lands at the lowest address. On a write the value is split into bytes that go to consecutive addresses in the chosen order. On a read the same bytes are gathered back in that order into a right-aligned, zero-extended result.

Requests are single-cycle: one read or one write may be presented in each clock cycle. Read data and a valid flag appear one cycle after the request. Half-words must start on an even address and words on a multiple of four. A misaligned request, or one with the reserved size code, raises an error flag in the following cycle and leaves the memory untouched. Byte order affects only where bytes are placed, so software on either convention can share the store. A value read in the opposite order from the one it was written in comes back byte-reversed.

Top module: `endian_byte_store`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `rvalid` and `err` are 0 and `rdata` is 0.
- R2: With `big_endian`=1, a word write of 0x87654321 at address A stores 0x87, 0x65, 0x43, 0x21 at A, A+1, A+2, A+3 as seen by byte reads.
- R3: With `big_endian`=0, the same word write stores 0x21, 0x43, 0x65, 0x87 at A, A+1, A+2, A+3.
- R4: A half-word write (size code 2'b01) stores its upper byte at the lower address when `big_endian`=1 and its lower byte there when `big_endian`=0. A half-word read returns the pair in the same order with bits 31:16 zero.
- R5: A byte read (size code 2'b00) returns the stored byte in bits 7:0 with bits 31:8 zero.
- R6: A value written with one size and mode and read back with the same size, address and mode is returned unchanged.
- R7: A word written in one mode and read in the other is returned with its four bytes in reverse order.
- R8: A half-word at an odd address or a word at an address not a multiple of four is rejected. `err` is 1 in the next cycle, `rvalid` stays 0, `rdata` stays 0, and no byte of the memory changes.
- R9: Size code 2'b11 is reserved. It is rejected exactly as in R8, at any address.
- R10: For an accepted read, `rvalid` is 1 and `rdata` holds the result in exactly the next cycle. In every other cycle `rvalid` is 0 and `rdata` is 0.
- R11: A byte or half-word write changes only the addressed bytes. The other bytes of the same aligned word keep their values.
- R12: `err` is 1 only in the cycle after a rejected request. Accepted requests and idle cycles leave it 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Byte address of the lowest byte touched |
| req_size | input | 2 | 2'b00 byte, 2'b01 half-word, 2'b10 word, 2'b11 reserved |
| big_endian | input | 1 | 1 = most significant byte at the lowest address, 0 = least significant byte there |
| wdata | input | 32 | Write value, right-aligned (a byte in 7:0, a half-word in 15:0) |
| rdata | output | 32 | Read result, right-aligned and zero-extended, 0 when rvalid is 0 |
| rvalid | output | 1 | rdata holds the result of the read accepted in the previous cycle |
| err | output | 1 | The request of the previous cycle was rejected |

## Verification
The hardest case to reach from the ports is a mix of byte orders inside one aligned word. One example is a half-word in one mode sitting beside bytes written in the other, then read back as a whole word in a third combination. Only that case shows that the write steering and the read gathering place every lane the same way. The directed part builds such words on purpose, for example a byte write inside a little-endian word and cross-mode word reads. A long random run then mixes sizes, modes, aligned and misaligned addresses and idle cycles at random. It does this over a deliberately small store, so that the same words are rewritten many times in different orders.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } ebs_size_e;

  // Routing of one byte lane: whether the access covers it, and which
  // byte of the right-aligned value it carries.
  typedef struct packed {
    logic       hit;
    logic [1:0] pos;
  } ebs_lane_t;

  function automatic ebs_lane_t lane_route(input logic [1:0] lane,
                                           input logic [1:0] off,
                                           input ebs_size_e  sz,
                                           input logic       big);
    ebs_lane_t  r;
    logic [2:0] span;
    logic [2:0] rel;
    case (sz)
      SZ_BYTE: span = 3'd1;
      SZ_HALF: span = 3'd2;
      SZ_WORD: span = 3'd4;
      default: span = 3'd0;
    endcase
    rel   = {1'b0, lane} - {1'b0, off};
    r.hit = (rel < span);
    r.pos = big ? 2'(span - 3'd1 - rel) : rel[1:0];
    return r;
  endfunction

endpackage

// File: rtl/ebs_align_chk.sv
module ebs_align_chk
  import ebs_pkg::*;
(
  input  logic [1:0] off,
  input  ebs_size_e  size,
  output logic       legal
);

  always_comb begin
    case (size)
      SZ_BYTE: legal = 1'b1;
      SZ_HALF: legal = ~off[0];
      SZ_WORD: legal = (off == 2'b00);
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/ebs_lane_steer.sv
module ebs_lane_steer
  import ebs_pkg::*;
(
  input  logic [1:0]                   off,
  input  ebs_size_e                    size,
  input  logic                         big,
  input  logic [LANES*BYTE_W-1:0]      wdata,
  output logic [LANES-1:0]             lane_en,
  output logic [LANES-1:0][BYTE_W-1:0] lane_byte
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ebs_lane_t route;
    assign route        = lane_route(2'(g), off, size, big);
    assign lane_en[g]   = route.hit;
    assign lane_byte[g] = wdata[{route.pos, 3'b000} +: BYTE_W];
  end

endmodule

// File: rtl/ebs_byte_bank.sv
module ebs_byte_bank #(
  parameter int ROWS   = 16,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] cells [ROWS];
  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[row] <= din;
    end
  end

  always_comb begin
    dout_d = dout_q;
    if (rd_en) begin
      dout_d = cells[row];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else begin
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/ebs_read_gather.sv
module ebs_read_gather
  import ebs_pkg::*;
(
  input  logic [LANES-1:0][BYTE_W-1:0] lane_byte,
  input  logic [1:0]                   off,
  input  ebs_size_e                    size,
  input  logic                         big,
  output logic [LANES*BYTE_W-1:0]      value
);

  ebs_lane_t route [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_route
    assign route[g] = lane_route(2'(g), off, size, big);
  end

  always_comb begin
    value = '0;
    for (int l = 0; l < LANES; l++) begin
      if (route[l].hit) begin
        value[{route[l].pos, 3'b000} +: BYTE_W] = lane_byte[l];
      end
    end
  end

endmodule

// File: rtl/endian_byte_store.sv
module endian_byte_store
  import ebs_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  parameter int ADDR_W      = $clog2(DEPTH_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              big_endian,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              err
);

  localparam int ROWS   = DEPTH_BYTES / LANES;
  localparam int ROW_W  = ADDR_W - 2;
  localparam int WORD_W = LANES * BYTE_W;

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  // request decode
  ebs_size_e         size_e;
  logic [1:0]        off;
  logic [ROW_W-1:0]  row;
  logic              legal;
  logic              wr_go;
  logic              rd_go;

  assign size_e = ebs_size_e'(req_size);
  assign off    = req_addr[1:0];
  assign row    = req_addr[ADDR_W-1:2];

  ebs_align_chk u_align (
    .off   (off),
    .size  (size_e),
    .legal (legal)
  );

  assign wr_go = req_valid &  req_we & legal;
  assign rd_go = req_valid & ~req_we & legal;

  // write steering and byte banks
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][BYTE_W-1:0] lane_wbyte;
  logic [LANES-1:0][BYTE_W-1:0] lane_rbyte;

  ebs_lane_steer u_steer (
    .off       (off),
    .size      (size_e),
    .big       (big_endian),
    .wdata     (wdata),
    .lane_en   (lane_en),
    .lane_byte (lane_wbyte)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    ebs_byte_bank #(
      .ROWS   (ROWS),
      .ROW_W  (ROW_W),
      .DATA_W (BYTE_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_int_n),
      .wr_en (wr_go & lane_en[g]),
      .rd_en (rd_go),
      .row   (row),
      .din   (lane_wbyte[g]),
      .dout  (lane_rbyte[g])
    );
  end

  // read-side request state: next-state
  logic       rvalid_d, rvalid_q;
  logic       err_d,    err_q;
  logic [1:0] off_d,    off_q;
  ebs_size_e  size_d,   size_q;
  logic       big_d,    big_q;

  always_comb begin
    rvalid_d = rd_go;
    err_d    = req_valid & ~legal;
    off_d    = off_q;
    size_d   = size_q;
    big_d    = big_q;
    if (rd_go) begin
      off_d  = off;
      size_d = size_e;
      big_d  = big_endian;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      off_q    <= 2'b00;
      size_q   <= SZ_BYTE;
      big_q    <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
      off_q    <= off_d;
      size_q   <= size_d;
      big_q    <= big_d;
    end
  end

  // read gathering
  logic [WORD_W-1:0] merged;

  ebs_read_gather u_gather (
    .lane_byte (lane_rbyte),
    .off       (off_q),
    .size      (size_q),
    .big       (big_q),
    .value     (merged)
  );

  assign rdata  = rvalid_q ? merged : '0;
  assign rvalid = rvalid_q;
  assign err    = err_q;

endmodule

// File: rtl/endian_byte_store_chk.sv
module endian_byte_store_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic [1:0]  addr_lo,
  input logic [1:0]  req_size,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic        err
);

  logic [1:0] up_q;
  logic       live;
  logic       ok_req;
  logic       rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 2'd0;
    end else if (up_q != 2'd3) begin
      up_q <= up_q + 2'd1;
    end
  end

  assign live   = (up_q == 2'd3);
  assign ok_req = (req_size == 2'b00) ||
                  (req_size == 2'b01 && !addr_lo[0]) ||
                  (req_size == 2'b10 && addr_lo == 2'b00);
  assign rd_req = req_valid && !req_we;

  AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    live && rd_req && ok_req |=> rvalid); // R10

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid); // R10

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == 32'd0); // R10

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    live && req_valid && !ok_req |=> err && !rvalid); // R8

  AST_RSVD_SIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    live && req_valid && req_size == 2'b11 |=> err); // R9

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !err); // R12

  AST_ERR_ON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ok_req |=> !err); // R12

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_size == 2'b00 |=> rdata[31:8] == 24'd0); // R5

  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_size == 2'b01 |=> rdata[31:16] == 16'd0); // R4

endmodule

bind endian_byte_store endian_byte_store_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .addr_lo   (req_addr[1:0]),
  .req_size  (req_size),
  .rdata     (rdata),
  .rvalid    (rvalid),
  .err       (err)
);

// File: tb/endian_byte_store_tb_top.sv
module endian_byte_store_tb_top;

  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_we;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          big_endian;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          err;

  always #5 clk = ~clk;

  endian_byte_store #(.DEPTH_BYTES(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .big_endian (big_endian),
    .wdata      (wdata),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .err        (err)
  );

  int          n_chk   = 0;
  int          n_fail  = 0;
  string       cur_req = "R1";
  bit          done    = 0;
  logic [7:0]  ref_mem [DEPTH];
  logic        exp_rv  = 1'b0;
  logic        exp_er  = 1'b0;
  logic [31:0] exp_rd  = 32'd0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    int  n;
    int  k;
    bit  bad;
    exp_rv = 1'b0;
    exp_er = 1'b0;
    exp_rd = 32'd0;
    if (rst_n && req_valid) begin
      case (req_size)
        2'b00:   n = 1;
        2'b01:   n = 2;
        2'b10:   n = 4;
        default: n = 0;
      endcase
      bad = (n == 0) || ((int'(req_addr) % n) != 0);
      if (bad) begin
        exp_er = 1'b1;
      end else if (req_we) begin
        for (int j = 0; j < n; j++) begin
          k = big_endian ? (n - 1 - j) : j;
          ref_mem[int'(req_addr) + j] = wdata[8*k +: 8];
        end
      end else begin
        for (int j = 0; j < n; j++) begin
          k = big_endian ? (n - 1 - j) : j;
          exp_rd[8*k +: 8] = ref_mem[int'(req_addr) + j];
        end
        exp_rv = 1'b1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    chk(cur_req, "cycle rvalid", {31'd0, rvalid}, {31'd0, exp_rv});
    chk(cur_req, "cycle err",    {31'd0, err},    {31'd0, exp_er});
    chk(cur_req, "cycle rdata",  rdata,           exp_rd);
  end

  task automatic op(input bit we, input int addr, input logic [1:0] sz,
                    input bit big, input logic [31:0] wd,
                    output logic [31:0] rd, output logic rv, output logic er);
    req_valid  = 1'b1;
    req_we     = we;
    req_addr   = AW'(addr);
    req_size   = sz;
    big_endian = big;
    wdata      = wd;
    @(posedge clk);
    @(negedge clk);
    rd = rdata;
    rv = rvalid;
    er = err;
    req_valid = 1'b0;
    req_we    = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [1:0] sz, input bit big,
                    input logic [31:0] wd, input string req);
    logic [31:0] rd;
    logic rv, er;
    op(1'b1, addr, sz, big, wd, rd, rv, er);
    chk(req, "write err", {31'd0, er}, 32'd0);
    chk(req, "write rvalid", {31'd0, rv}, 32'd0);
  endtask

  task automatic rd_expect(input int addr, input logic [1:0] sz, input bit big,
                           input logic [31:0] exp, input string req);
    logic [31:0] rd;
    logic rv, er;
    op(1'b0, addr, sz, big, 32'd0, rd, rv, er);
    chk(req, "read rvalid", {31'd0, rv}, 32'd1);
    chk(req, "read data", rd, exp);
  endtask

  task automatic reject(input bit we, input int addr, input logic [1:0] sz,
                        input string req);
    logic [31:0] rd;
    logic rv, er;
    op(we, addr, sz, 1'b1, 32'hFFFF_FFFF, rd, rv, er);
    chk(req, "reject err", {31'd0, er}, 32'd1);
    chk(req, "reject rvalid", {31'd0, rv}, 32'd0);
    chk(req, "reject rdata", rd, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_we     = 1'b0;
    req_addr   = '0;
    req_size   = 2'b00;
    big_endian = 1'b0;
    wdata      = 32'd0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "reset rvalid", {31'd0, rvalid}, 32'd0);
    chk("R1", "reset err", {31'd0, err}, 32'd0);
    chk("R1", "reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "post-reset rvalid", {31'd0, rvalid}, 32'd0);
    chk("R1", "post-reset rdata", rdata, 32'd0);

    // clear the store
    cur_req = "R6";
    for (int a = 0; a < DEPTH; a += 4) wr(a, 2'b10, 1'b0, 32'd0, "R6");

    // R2 big-endian word placement
    cur_req = "R2";
    wr(0, 2'b10, 1'b1, 32'h8765_4321, "R2");
    rd_expect(0, 2'b00, 1'b1, 32'h87, "R2");
    rd_expect(1, 2'b00, 1'b0, 32'h65, "R2");
    rd_expect(2, 2'b00, 1'b1, 32'h43, "R2");
    rd_expect(3, 2'b00, 1'b0, 32'h21, "R2");

    // R3 little-endian word placement, byte reads also check R5
    cur_req = "R3";
    wr(4, 2'b10, 1'b0, 32'h8765_4321, "R3");
    rd_expect(4, 2'b00, 1'b0, 32'h21, "R3");
    rd_expect(5, 2'b00, 1'b1, 32'h43, "R3");
    rd_expect(6, 2'b00, 1'b0, 32'h65, "R5");
    rd_expect(7, 2'b00, 1'b1, 32'h87, "R5");

    // R6 round trip, R7 cross-mode reversal
    cur_req = "R6";
    rd_expect(0, 2'b10, 1'b1, 32'h8765_4321, "R6");
    rd_expect(4, 2'b10, 1'b0, 32'h8765_4321, "R6");
    cur_req = "R7";
    rd_expect(0, 2'b10, 1'b0, 32'h2143_6587, "R7");
    rd_expect(4, 2'b10, 1'b1, 32'h2143_6587, "R7");

    // R4 half-word placement and read
    cur_req = "R4";
    wr(10, 2'b01, 1'b1, 32'h0000_BEEF, "R4");
    wr(12, 2'b01, 1'b0, 32'h0000_BEEF, "R4");
    rd_expect(10, 2'b00, 1'b0, 32'hBE, "R4");
    rd_expect(11, 2'b00, 1'b0, 32'hEF, "R4");
    rd_expect(12, 2'b00, 1'b0, 32'hEF, "R4");
    rd_expect(13, 2'b00, 1'b0, 32'hBE, "R4");
    rd_expect(10, 2'b01, 1'b1, 32'h0000_BEEF, "R4");
    rd_expect(12, 2'b01, 1'b1, 32'h0000_EFBE, "R4");
    rd_expect(8, 2'b10, 1'b1, 32'h0000_BEEF, "R4");

    // R11 partial writes keep neighbours
    cur_req = "R11";
    wr(5, 2'b00, 1'b1, 32'hFFFF_FF5A, "R11");
    rd_expect(4, 2'b10, 1'b0, 32'h8765_5A21, "R11");
    wr(2, 2'b01, 1'b0, 32'h0000_C3D4, "R11");
    rd_expect(0, 2'b10, 1'b1, 32'h8765_D4C3, "R11");

    // R8 misaligned requests
    cur_req = "R8";
    reject(1'b1, 1, 2'b01, "R8");
    reject(1'b1, 6, 2'b10, "R8");
    reject(1'b0, 2, 2'b10, "R8");
    reject(1'b0, 7, 2'b01, "R8");
    rd_expect(0, 2'b10, 1'b1, 32'h8765_D4C3, "R8");
    rd_expect(4, 2'b10, 1'b0, 32'h8765_5A21, "R8");

    // R9 reserved size
    cur_req = "R9";
    reject(1'b1, 0, 2'b11, "R9");
    reject(1'b0, 8, 2'b11, "R9");
    rd_expect(0, 2'b10, 1'b1, 32'h8765_D4C3, "R9");

    // R10 / R12 idle cycle after a read
    cur_req = "R10";
    rd_expect(12, 2'b10, 1'b1, 32'hEFBE_0000, "R10");
    @(negedge clk);
    chk("R10", "idle rvalid", {31'd0, rvalid}, 32'd0);
    chk("R10", "idle rdata", rdata, 32'd0);
    chk("R12", "idle err", {31'd0, err}, 32'd0);

    // random mix, checked every clock against the model
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rd;
      logic rv, er;
      int a;
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      a  = $urandom_range(0, DEPTH - 1);
      if ($urandom_range(0, 3) != 0) begin
        if (sz == 2'b01) a = a & ~1;
        if (sz == 2'b10) a = a & ~3;
      end
      op(1'($urandom_range(0, 1)), a, sz, 1'($urandom_range(0, 1)),
         $urandom(), rd, rv, er);
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule